// File: doc/BRIEF.md
# Dual-Lane Serial Flash Read Responder

This block is the device-side logic of a serial flash that answers a dual-lane fast read. The host pulls the active-low select low and clocks a command byte on lane 0. It then sends a 24-bit address and a mode byte, two bits per clock on both lanes. The block then returns bytes from a small internal array, two bits per clock. The block samples its lanes on the rising serial clock and changes its outputs on the falling serial clock.

The mode byte sets a continuous-read flag, and this flag survives the select going high. While the flag is set, the next transaction skips the command byte and opens directly with the address, which saves eight clocks. A mode-reset command clears the flag, so that ordinary single-lane commands are accepted again.

The controller is one state machine with these states:
- `ST_OPCODE`: receives the command byte.
- `ST_ADDR`: receives the address.
- `ST_MODE`: receives the mode byte.
- `ST_DATA`: drives read data.
- `ST_SKIP`: discards the rest of a transaction that carries an unsupported command.

Its transitions are these:
- select-high: goes to `ST_ADDR` when the continuous flag is set, otherwise to `ST_OPCODE`.
- cmd-read: `ST_OPCODE` to `ST_ADDR`.
- cmd-other: `ST_OPCODE` to `ST_SKIP`.
- addr-done: `ST_ADDR` to `ST_MODE`.
- mode-done: `ST_MODE` to `ST_DATA`.

Top module: `dio_read_responder`

## Requirements
- R1: After reset both lanes are released (`io_oe` = 00) and continuous mode is off, so the first transaction must start with the command byte.
- R2: Outside continuous mode, the command is 8 bits taken MSB-first from `io_in[0]` on rising clocks. The value 0xBB is then followed by 12 address clocks. In each address clock `io_in[1]` carries the higher bit of the pair, and the address is sent MSB-first.
- R3: The mode byte is taken over 4 clocks, with the higher bit of each pair on `io_in[1]`. If its upper nibble is 0xA, continuous mode is set and the next transaction starts directly with the address. The lower nibble has no effect.
- R4: A fully received mode byte whose upper nibble is not 0xA clears continuous mode, so the next transaction needs the command byte.
- R5: The first data pair appears on the falling edge of the last mode clock. Each later pair appears on the following falling edges. Bytes go MSB-first, with the higher bit of each pair on `io_out[1]`. The array byte at index i is ((37*i + 11) mod 256) XOR 0xC3.
- R6: `io_oe` stays 00 during the command, address and mode phases. It is 11 only while data is being driven.
- R7: After each 4-clock byte the array index increments, and it wraps from DEPTH-1 (63 by default) to 0. The index is the low bits of the address.
- R8: Select high releases both lanes at once and aborts the transaction. A transaction aborted before its mode byte is complete leaves the continuous flag unchanged.
- R9: A command other than 0xBB or 0xFF makes the rest of the transaction ignored. The lanes stay released, and the next transaction starts from the command phase again.
- R10: Command 0xFF clears continuous mode. While in continuous mode, a transaction that ends after exactly 8 clocks with `io_in[0]` high on each of them also clears it. In that transaction `io_in[1]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs sampled rising, outputs change falling |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 2 | Lane input values from the host |
| io_out | output | 2 | Lane output values toward the host |
| io_oe | output | 2 | Lane output enables (1 = drive) |

## Verification
The bench attacks continuous mode from several sides:
- A design that latched the flag from an aborted transaction, or that did not keep it across the select going high, would misread the address of the next transaction, and the data that came back would be wrong.
- Mode values 0xA0 and 0xA5, and a mode byte of all ones, separate a design that looks at the whole byte from one that looks only at the upper nibble.
- Reads that cross index 63 catch a design whose index does not wrap.
- Sampling right after the last mode clock catches a design whose data arrives one clock off.
- The 8-clock reset pattern, sent with random values on lane 1, catches a design that fails to clear the flag or that looks at the wrong lane.

// File: rtl/dio_pkg.sv
package dio_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE = 3'd0,
        ST_ADDR   = 3'd1,
        ST_MODE   = 3'd2,
        ST_DATA   = 3'd3,
        ST_SKIP   = 3'd4
    } dio_state_e;

    localparam logic [7:0] CMD_DUAL_READ  = 8'hBB;
    localparam logic [7:0] CMD_MODE_CLEAR = 8'hFF;
    localparam logic [3:0] CONT_NIBBLE    = 4'hA;

    // Array contents are computed, never listed.
    function automatic logic [7:0] array_byte(input int unsigned idx);
        logic [7:0] lin;
        lin = 8'((idx * 37 + 11) % 256);
        return lin ^ 8'hC3;
    endfunction

endpackage

// File: rtl/dio_byte_rom.sv
module dio_byte_rom #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign cells[g] = dio_pkg::array_byte(g);
    end

    assign rd_byte = cells[rd_idx];
endmodule

// File: rtl/dio_ctrl.sv
module dio_ctrl #(
    parameter int ADDR_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W      = $clog2(DEPTH),
    localparam int ADDR_PAIRS = ADDR_W / 2,
    localparam int CNT_W      = $clog2(ADDR_PAIRS + 1)
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic [1:0]       io_in,
    input  logic [7:0]       rom_byte,
    output logic [IDX_W-1:0] rom_idx,
    output logic             data_en,
    output logic [1:0]       data_pair
);
    import dio_pkg::*;

    localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_PAIRS - 1);
    localparam logic [CNT_W-1:0] MODE_LAST  = CNT_W'(3);
    localparam logic [CNT_W-1:0] CLEAR_CLKS = CNT_W'(8);

    dio_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [7:0]        op_q, op_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [3:0]        mhi_q, mhi_d;
    logic [1:0]        pcnt_q, pcnt_d;
    logic              cont_q, cont_d;
    logic              entry_cont_q, entry_cont_d;
    logic              ones_q, ones_d;
    logic              clear_short;
    logic [7:0]        op_full;

    // 8-clock all-ones pattern while in continuous mode
    assign clear_short = (state_q == ST_ADDR) && entry_cont_q &&
                         (cnt_q == CLEAR_CLKS) && ones_q;
    assign op_full     = {op_q[6:0], io_in[0]};

    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        op_d         = op_q;
        addr_d       = addr_q;
        mhi_d        = mhi_q;
        pcnt_d       = pcnt_q;
        cont_d       = cont_q;
        entry_cont_d = entry_cont_q;
        ones_d       = ones_q;
        if (cs_n) begin
            // select-high
            cont_d       = clear_short ? 1'b0 : cont_q;
            entry_cont_d = cont_d;
            state_d      = cont_d ? ST_ADDR : ST_OPCODE;
            cnt_d        = '0;
            pcnt_d       = '0;
            ones_d       = 1'b1;
        end else begin
            unique case (state_q)
                ST_OPCODE: begin
                    op_d  = op_full;
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == OP_LAST) begin
                        cnt_d = '0;
                        if (op_full == CMD_DUAL_READ) begin
                            state_d = ST_ADDR;             // cmd-read
                        end else begin
                            state_d = ST_SKIP;             // cmd-other
                            if (op_full == CMD_MODE_CLEAR) cont_d = 1'b0;
                        end
                    end
                end
                ST_ADDR: begin
                    addr_d = {addr_q[ADDR_W-3:0], io_in};
                    ones_d = ones_q & io_in[0];
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == ADDR_LAST) begin
                        state_d = ST_MODE;                 // addr-done
                        cnt_d   = '0;
                    end
                end
                ST_MODE: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == '0)          mhi_d[3:2] = io_in;
                    if (cnt_q == CNT_W'(1))   mhi_d[1:0] = io_in;
                    if (cnt_q == MODE_LAST) begin
                        cont_d  = (mhi_q == CONT_NIBBLE);
                        state_d = ST_DATA;                 // mode-done
                        cnt_d   = '0;
                        pcnt_d  = '0;
                    end
                end
                ST_DATA: begin
                    pcnt_d = pcnt_q + 1'b1;
                    if (pcnt_q == 2'd3) addr_d = addr_q + 1'b1;
                end
                ST_SKIP: begin
                    state_d = ST_SKIP;
                end
                default: state_d = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_OPCODE;
            cnt_q        <= '0;
            op_q         <= '0;
            addr_q       <= '0;
            mhi_q        <= '0;
            pcnt_q       <= '0;
            cont_q       <= 1'b0;
            entry_cont_q <= 1'b0;
            ones_q       <= 1'b1;
        end else begin
            state_q      <= state_d;
            cnt_q        <= cnt_d;
            op_q         <= op_d;
            addr_q       <= addr_d;
            mhi_q        <= mhi_d;
            pcnt_q       <= pcnt_d;
            cont_q       <= cont_d;
            entry_cont_q <= entry_cont_d;
            ones_q       <= ones_d;
        end
    end

    always_comb begin
        rom_idx = addr_q[IDX_W-1:0];
        data_en = (state_q == ST_DATA);
        unique case (pcnt_q)
            2'd0: data_pair = rom_byte[7:6];
            2'd1: data_pair = rom_byte[5:4];
            2'd2: data_pair = rom_byte[3:2];
            2'd3: data_pair = rom_byte[1:0];
            default: data_pair = 2'b00;
        endcase
    end

    p_cont_set_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && state_q == ST_MODE && cnt_q == MODE_LAST && mhi_q == CONT_NIBBLE) |=> cont_q);

    p_cont_clear_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && state_q == ST_MODE && cnt_q == MODE_LAST && mhi_q != CONT_NIBBLE) |=> !cont_q);

    p_skip_cmd_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (cs_n && cont_q && !clear_short) |=> (state_q == ST_ADDR));

    p_index_step_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cs_n && state_q == ST_DATA && pcnt_q == 2'd3) |=>
        (addr_q[IDX_W-1:0] == IDX_W'($past(addr_q[IDX_W-1:0]) + 1'b1)));

    p_short_clear_r10: assert property (@(posedge sclk) disable iff (!rst_n)
        (cs_n && clear_short) |=> (!cont_q && state_q == ST_OPCODE));

    p_abort_keep_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        (cs_n && !clear_short) |=> (cont_q == $past(cont_q)));
endmodule

// File: rtl/dio_lane_drv.sv
module dio_lane_drv (
    input  logic       sclk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       data_en,
    input  logic [1:0] data_pair,
    output logic [1:0] io_out,
    output logic [1:0] io_oe
);
    logic       drive_q;
    logic [1:0] pair_q;

    // Output stage advances on the falling clock.
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            pair_q  <= 2'b00;
        end else if (cs_n || !data_en) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= 1'b1;
            pair_q  <= data_pair;
        end
    end

    assign io_out = pair_q;
    assign io_oe  = {2{drive_q & ~cs_n}};

    p_drive_in_data_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        (io_oe != 2'b00) |-> data_en);
endmodule

// File: rtl/dio_read_responder.sv
module dio_read_responder #(
    parameter int ADDR_W = 24,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic       sclk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [1:0] io_in,
    output logic [1:0] io_out,
    output logic [1:0] io_oe
);
    logic [IDX_W-1:0] rom_idx;
    logic [7:0]       rom_byte;
    logic             data_en;
    logic [1:0]       data_pair;

    dio_byte_rom #(.DEPTH(DEPTH)) u_rom (
        .rd_idx  (rom_idx),
        .rd_byte (rom_byte)
    );

    dio_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .io_in     (io_in),
        .rom_byte  (rom_byte),
        .rom_idx   (rom_idx),
        .data_en   (data_en),
        .data_pair (data_pair)
    );

    dio_lane_drv u_drv (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .data_en   (data_en),
        .data_pair (data_pair),
        .io_out    (io_out),
        .io_oe     (io_oe)
    );

    p_release_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |-> (io_oe == 2'b00));

    p_lanes_paired_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        (io_oe == 2'b00) || (io_oe == 2'b11));
endmodule

// File: tb/dio_read_responder_bench.sv
module dio_read_responder_bench;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] io_in = 2'b00;
    logic [1:0] io_out;
    logic [1:0] io_oe;

    int checks = 0;
    int errors = 0;
    bit model_cont = 1'b0;
    bit quiet_bad = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dio_read_responder u_dio_read_responder (
        .sclk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    function automatic logic [7:0] exp_byte(input int idx);
        return 8'(((idx % DEPTH) * 37 + 11) % 256) ^ 8'hC3;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] v);
        @(posedge clk); #2;
        cs_n = 1'b0;
        io_in = v;
        if (io_oe != 2'b00) quiet_bad = 1'b1;
    endtask

    task automatic send_op(input logic [7:0] op);
        for (int i = 7; i >= 0; i--) step({1'b0, op[i]});
    endtask

    task automatic send_addr(input logic [23:0] adr, input int pairs);
        for (int k = 11; k > 11 - pairs; k--) step(adr[2*k +: 2]);
    endtask

    task automatic send_mode(input logic [7:0] m);
        for (int k = 3; k >= 0; k--) step(m[2*k +: 2]);
        @(posedge clk);
    endtask

    task automatic read_bytes(input int start, input int n, input string rq);
        for (int b = 0; b < n; b++) begin
            logic [7:0] got;
            bit oe_ok;
            got = 8'h00;
            oe_ok = 1'b1;
            for (int p = 0; p < 4; p++) begin
                @(negedge clk); #3;
                got = {got[5:0], io_out};
                if (io_oe != 2'b11) oe_ok = 1'b0;
            end
            chk(got == exp_byte(start + b), rq, 32'(got), 32'(exp_byte(start + b)));
            chk(oe_ok, "R6 lanes driven in data", 32'(io_oe), 32'h3);
        end
    endtask

    task automatic end_txn(input string rq);
        @(posedge clk); #2;
        cs_n = 1'b1;
        io_in = 2'b00;
        #1;
        chk(io_oe == 2'b00, "R8 release on select high", 32'(io_oe), 32'h0);
        chk(!quiet_bad, rq, 32'(quiet_bad), 32'h0);
        quiet_bad = 1'b0;
        @(posedge clk); @(posedge clk);
    endtask

    // full read honoring the model's continuous state
    task automatic full_read(input logic [23:0] adr, input logic [7:0] m, input int n, input string rq);
        if (!model_cont) send_op(8'hBB);
        send_addr(adr, 12);
        send_mode(m);
        read_bytes(int'(adr[5:0]), n, rq);
        end_txn("R6 lanes quiet before data");
        model_cont = (m[7:4] == 4'hA);
    endtask

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #2;
        chk(io_oe == 2'b00, "R1 reset releases lanes", 32'(io_oe), 32'h0);
        rst_n = 1'b1;
        @(posedge clk); @(posedge clk);

        // R1/R2: plain read needs opcode
        full_read(24'h000005, 8'h00, 3, "R2 plain read data");
        // R3: continuous set, lower nibble ignored
        full_read(24'h123410, 8'hA5, 2, "R3 read setting continuous");
        full_read(24'h00003E, 8'hA0, 4, "R3 R7 no-opcode read wraps");
        // R8: abort mid-address keeps continuous
        send_addr(24'hFFFFFF, 5);
        end_txn("R8 abort quiet");
        full_read(24'h000020, 8'h3C, 2, "R8 continuous kept after abort");
        // R4: now normal, opcode needed
        full_read(24'hABCD3F, 8'hFF, 2, "R4 opcode required again");
        // R9: unsupported command ignored
        send_op(8'h03);
        for (int i = 0; i < 16; i++) step(2'(i));
        end_txn("R9 unsupported command keeps lanes quiet");
        full_read(24'h000011, 8'hAF, 1, "R9 normal read after ignored command");
        // R10: short all-ones on lane 0 clears continuous, lane 1 random
        for (int i = 0; i < 8; i++) step({1'($urandom), 1'b1});
        end_txn("R10 short clear quiet");
        model_cont = 1'b0;
        full_read(24'h000001, 8'hA1, 2, "R10 opcode needed after short clear");
        // R10: 0xFF command form, while already normal after a non-A mode
        full_read(24'h000002, 8'h50, 1, "R4 mode 0x50 returns to normal");
        send_op(8'hFF);
        end_txn("R10 clear command quiet");
        full_read(24'h000009, 8'h00, 1, "R10 read after clear command");

        // random mix
        for (int it = 0; it < 24; it++) begin
            int kind;
            logic [23:0] adr;
            logic [7:0] m;
            kind = int'($urandom_range(0, 5));
            adr = 24'($urandom);
            m = ($urandom_range(0, 1) == 1) ? {4'hA, 4'($urandom)} : 8'($urandom);
            if (kind < 4) begin
                full_read(adr, m, int'($urandom_range(1, 5)), "R5 R7 random read");
            end else begin
                int pairs;
                bit ones;
                pairs = int'($urandom_range(1, 11));
                if (!model_cont) send_op(8'hBB);
                send_addr(adr, pairs);
                end_txn("R8 random abort quiet");
                ones = 1'b1;
                for (int k = 0; k < pairs; k++) ones &= adr[2*(11-k)];
                if (model_cont && pairs == 8 && ones) model_cont = 1'b0;
            end
        end
        full_read(24'h00003F, 8'h00, 2, "R7 final wrap read");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule